// File: doc/BRIEF.md
# Endian-Aware Bus Width Adapter

This block joins an internal access port, which speaks in whole values of one, two or four bytes or in bursts of 8, 16 or 32 bytes, to an external memory data bus that is 8, 16 or 32 bits wide. It splits each request into as many external cycles as the device width requires and steps the cycle address by the bus width. Bytes are placed on the external lanes, or collected from them, according to a byte-order mode. That mode is captured while reset is held and stays fixed until the next reset.

Bursts are served as a series of longword items. The first item is the one the requester asked for, and the rest follow it with wraparound inside the aligned block of the burst's size. The adapter keeps the bus for itself from the first cycle to the last. Each finished item is reported with a one-cycle beat strobe, and the last beat also carries a done strobe. A request that is misaligned or that names a width the region cannot use is refused with a one-cycle error pulse, and no bus cycle is issued for it.

Top module: `endian_width_adapter`

## Requirements
- R1: The byte order is sampled from mode_le_i on every clock edge while rst_n is low: 0 selects big endian and 1 selects little endian. Changes to mode_le_i after reset has been released have no effect.
- R2: bus_width_i codes 0, 1 and 2 select 1-, 2- and 4-byte buses. req_size_i codes 0, 1 and 2 select 1-, 2- and 4-byte values. A single access takes max(1, size/width) cycles. Its first cycle address is the request address, and each later cycle adds the width in bytes.
- R3: Lane L (bits 8L+7..8L) of a W-byte bus, in a cycle at address a, carries the byte at (a rounded down to a multiple of W) + L in little endian, or + (W-1-L) in big endian. bus_be_o is set for exactly the lanes of the current sub-access. It is never set for a lane at or above W, and it is zero when bus_cyc_o is low. bus_we_o follows the request's write flag.
- R4: In big endian the byte at the lowest address is the most significant byte of the value; in little endian it is the least significant. Read values appear right-justified in rdata_o with the upper bytes zero. Write values are taken right-justified from req_wdata_i. Read lanes that are not enabled have no effect.
- R5: beat_o pulses for one cycle, with rdata_o valid, in the cycle after the final ack of each item. done_o pulses together with the last beat of the request.
- R6: req_size_i codes 3, 4 and 5 request 8-, 16- and 32-byte bursts, which run as 2, 4 or 8 longword items. The first item is at the request address. Each following item is 4 bytes higher, wrapping inside the aligned block whose size is the burst length.
- R7: In a burst write, item 0 takes its data from req_wdata_i at acceptance. Item k+1 takes its data from req_wdata_i in the cycle that carries the final ack of item k.
- R8: busy_o and bus_cyc_o rise in the cycle after a request is accepted and stay high without a gap until the cycle after the final ack. A request presented while busy is ignored.
- R9: While bus_ack_i is low, bus_addr_o, bus_be_o and bus_wdata_o hold their values.
- R10: A single access whose address is not a multiple of its size, or a burst whose address is not a multiple of 4, gives a one-cycle err_o pulse in the next cycle and issues no bus cycle.
- R11: Width code 3, width code 2 while narrow_region_i is high, and size codes above 5 are refused in the same way as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the byte order is captured while it is low |
| mode_le_i | input | 1 | Byte-order select sampled during reset (1 = little endian) |
| bus_width_i | input | 2 | Device width code of the addressed region |
| narrow_region_i | input | 1 | Region accepts only 8- or 16-bit widths |
| req_valid_i | input | 1 | Request strobe, taken only when idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 3 | Size code: log2 of the byte count |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_wdata_i | input | 32 | Write value, right-justified; next longword during bursts |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Request refused |
| beat_o | output | 1 | One item finished |
| done_o | output | 1 | Whole request finished |
| rdata_o | output | 32 | Read value of the item just finished |
| bus_cyc_o | output | 1 | External cycle active; bus held |
| bus_we_o | output | 1 | External cycle is a write |
| bus_addr_o | output | ADDR_W | Byte address of the current sub-access |
| bus_be_o | output | 4 | Lane enables |
| bus_wdata_o | output | 32 | Lane-ordered write data |
| bus_rdata_i | input | 32 | Lane-ordered read data |
| bus_ack_i | input | 1 | Current external cycle completes |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, bursts of up to 32 bytes, and the 32-bit bus option present. With these values every pairing of value size and bus width can be reached, in both byte orders, together with the full eight-item wrap of a 32-byte burst and the refusal of a 32-bit width in a narrow region. A byte-wide memory model behind the bus lanes lets reads and writes be judged against stored bytes. Wait states and a request presented mid-transfer exercise holding and ignoring.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
   localparam int LANES = 4;
   localparam int WORD_W = LANES * 8;

   // size code is log2 of the byte count; items never exceed one longword
   function automatic logic [1:0] item_log(input logic [2:0] size_code);
      return (size_code > 3'd2) ? 2'd2 : size_code[1:0];
   endfunction
endpackage

// File: rtl/ebw_req_check.sv
module ebw_req_check #(
   parameter int MAX_BURST_LOG = 5,
   parameter bit WIDE_BUS_OK   = 1'b1
) (
   input  logic [2:0] size_i,
   input  logic [1:0] addr_lo_i,
   input  logic [1:0] wsh_i,
   input  logic       narrow_i,
   output logic       ok_o
);
   logic [1:0] ilog;
   logic [1:0] align_mask;
   logic       size_ok;
   logic       wide_ok;
   logic       width_ok;
   logic       aligned;

   assign ilog       = ebw_pkg::item_log(size_i);
   assign align_mask = 2'((3'd1 << ilog) - 3'd1);
   assign aligned    = ((addr_lo_i & align_mask) == 2'd0);
   assign size_ok    = (int'(size_i) <= MAX_BURST_LOG);

   generate
      if (WIDE_BUS_OK) begin : g_wide
         assign wide_ok = ~narrow_i;
      end else begin : g_no_wide
         assign wide_ok = 1'b0;
      end
   endgenerate

   assign width_ok = (wsh_i == 2'd0) || (wsh_i == 2'd1) || ((wsh_i == 2'd2) && wide_ok);
   assign ok_o     = size_ok && width_ok && aligned;
endmodule

// File: rtl/ebw_addr_seq.sv
module ebw_addr_seq #(
   parameter int ADDR_W        = 32,
   parameter int MAX_BURST_LOG = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [2:0]        size_i,
   input  logic [1:0]        wsh_i,
   input  logic              ack_i,
   output logic              busy_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        wsh_o,
   output logic              sub_last_o,
   output logic              xfer_last_o
);
   localparam int LWC_W = MAX_BURST_LOG - 1;

   logic              busy_q;
   logic [ADDR_W-1:0] cur_q, lw_q, blk_mask_q, next_lw;
   logic [1:0]        sub_q, sub_init_q, sub_init, wsh_q;
   logic [LWC_W-1:0]  lwc_q, lw_init;
   logic [ADDR_W-1:0] blk_mask, step;
   logic [1:0]        ilog;

   assign ilog = ebw_pkg::item_log(size_i);

   always_comb begin
      if (ilog > wsh_i) sub_init = 2'((3'd1 << (ilog - wsh_i)) - 3'd1);
      else              sub_init = 2'd0;
      if (size_i >= 3'd3) lw_init = LWC_W'((32'd1 << (size_i - 3'd2)) - 32'd1);
      else                lw_init = '0;
      blk_mask = ADDR_W'((32'd1 << size_i) - 32'd1);
   end

   assign step    = ADDR_W'(1) << wsh_q;
   assign next_lw = (lw_q & ~blk_mask_q) | ((lw_q + ADDR_W'(4)) & blk_mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         cur_q      <= '0;
         lw_q       <= '0;
         blk_mask_q <= '0;
         sub_q      <= '0;
         sub_init_q <= '0;
         lwc_q      <= '0;
         wsh_q      <= '0;
      end else if (start_i) begin
         busy_q     <= 1'b1;
         cur_q      <= addr_i;
         lw_q       <= addr_i;
         blk_mask_q <= blk_mask;
         sub_q      <= sub_init;
         sub_init_q <= sub_init;
         lwc_q      <= lw_init;
         wsh_q      <= wsh_i;
      end else if (busy_q && ack_i) begin
         if (sub_q != 2'd0) begin
            sub_q <= sub_q - 2'd1;
            cur_q <= cur_q + step;
         end else if (lwc_q != '0) begin
            lwc_q <= lwc_q - LWC_W'(1);
            lw_q  <= next_lw;
            cur_q <= next_lw;
            sub_q <= sub_init_q;
         end else begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy_o      = busy_q;
   assign addr_o      = cur_q;
   assign wsh_o       = wsh_q;
   assign sub_last_o  = (sub_q == 2'd0);
   assign xfer_last_o = (lwc_q == '0);
endmodule

// File: rtl/ebw_lane_map.sv
module ebw_lane_map #(
   parameter int LANES = ebw_pkg::LANES
) (
   input  logic               le_i,
   input  logic [1:0]         wsh_i,
   input  logic [1:0]         ilog_i,
   input  logic [1:0]         cur_lo_i,
   input  logic [LANES*8-1:0] wval_i,
   input  logic [LANES*8-1:0] rbus_i,
   output logic [LANES-1:0]   be_o,
   output logic [LANES*8-1:0] wbus_o,
   output logic [LANES*8-1:0] rbytes_o
);
   int w_b, s_b, n_b, lo, wbase, ibase, o, b, off, v;

   always_comb begin
      be_o     = '0;
      wbus_o   = '0;
      rbytes_o = '0;
      w_b   = 1 << wsh_i;
      s_b   = 1 << ilog_i;
      n_b   = (w_b < s_b) ? w_b : s_b;
      lo    = int'(cur_lo_i);
      wbase = lo & ~(w_b - 1);
      ibase = lo & ~(s_b - 1);
      o = 0; b = 0; off = 0; v = 0;
      for (int l = 0; l < LANES; l++) begin
         o   = le_i ? l : (w_b - 1 - l);
         b   = wbase + o;
         off = b - ibase;
         v   = le_i ? off : (s_b - 1 - off);
         if ((l < w_b) && (b >= lo) && (b < lo + n_b)) begin
            be_o[l]             = 1'b1;
            wbus_o[l*8 +: 8]    = wval_i[v*8 +: 8];
            rbytes_o[v*8 +: 8]  = rbus_i[l*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/endian_width_adapter.sv
module endian_width_adapter #(
   parameter int ADDR_W        = 32,
   parameter int MAX_BURST_LOG = 5,
   parameter bit WIDE_BUS_OK   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_le_i,
   input  logic [1:0]        bus_width_i,
   input  logic              narrow_region_i,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [2:0]        req_size_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [31:0]       req_wdata_i,
   output logic              busy_o,
   output logic              err_o,
   output logic              beat_o,
   output logic              done_o,
   output logic [31:0]       rdata_o,
   output logic              bus_cyc_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [3:0]        bus_be_o,
   output logic [31:0]       bus_wdata_o,
   input  logic [31:0]       bus_rdata_i,
   input  logic              bus_ack_i
);
   localparam int WORD_W = ebw_pkg::WORD_W;

   generate
      if (MAX_BURST_LOG < 3 || MAX_BURST_LOG > 5) begin : g_bad_burst
         $error("MAX_BURST_LOG must lie in 3..5");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must be at least 6");
      end
      if (WORD_W != 32) begin : g_bad_word
         $error("lane count must give a 32-bit word");
      end
   endgenerate

   logic              le_q;
   logic              write_q;
   logic [1:0]        ilog_q;
   logic [31:0]       wval_q, racc_q, racc_next, rdata_q;
   logic              beat_q, done_q, err_q;
   logic              req_ok, accept, busy;
   logic [ADDR_W-1:0] cur_addr;
   logic [1:0]        wsh_cur;
   logic              sub_last, xfer_last, item_end;
   logic [3:0]        be;
   logic [31:0]       wbus, rbytes;

   ebw_req_check #(.MAX_BURST_LOG(MAX_BURST_LOG), .WIDE_BUS_OK(WIDE_BUS_OK)) u_check (
      .size_i    (req_size_i),
      .addr_lo_i (req_addr_i[1:0]),
      .wsh_i     (bus_width_i),
      .narrow_i  (narrow_region_i),
      .ok_o      (req_ok)
   );

   assign accept = req_valid_i && !busy && req_ok;

   ebw_addr_seq #(.ADDR_W(ADDR_W), .MAX_BURST_LOG(MAX_BURST_LOG)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (accept),
      .addr_i      (req_addr_i),
      .size_i      (req_size_i),
      .wsh_i       (bus_width_i),
      .ack_i       (bus_ack_i),
      .busy_o      (busy),
      .addr_o      (cur_addr),
      .wsh_o       (wsh_cur),
      .sub_last_o  (sub_last),
      .xfer_last_o (xfer_last)
   );

   ebw_lane_map #(.LANES(ebw_pkg::LANES)) u_lanes (
      .le_i     (le_q),
      .wsh_i    (wsh_cur),
      .ilog_i   (ilog_q),
      .cur_lo_i (cur_addr[1:0]),
      .wval_i   (wval_q),
      .rbus_i   (bus_rdata_i),
      .be_o     (be),
      .wbus_o   (wbus),
      .rbytes_o (rbytes)
   );

   assign item_end  = busy && bus_ack_i && sub_last;
   assign racc_next = racc_q | rbytes;

   // byte order is captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) le_q <= mode_le_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q <= 1'b0;
         ilog_q  <= 2'd0;
         wval_q  <= '0;
         racc_q  <= '0;
         rdata_q <= '0;
         beat_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         err_q  <= req_valid_i && !busy && !req_ok;
         beat_q <= item_end;
         done_q <= item_end && xfer_last;
         if (accept) begin
            write_q <= req_write_i;
            ilog_q  <= ebw_pkg::item_log(req_size_i);
            wval_q  <= req_wdata_i;
            racc_q  <= '0;
         end else if (item_end) begin
            rdata_q <= racc_next;
            racc_q  <= '0;
            if (!xfer_last) wval_q <= req_wdata_i;
         end else if (busy && bus_ack_i) begin
            racc_q <= racc_next;
         end
      end
   end

   assign busy_o      = busy;
   assign err_o       = err_q;
   assign beat_o      = beat_q;
   assign done_o      = done_q;
   assign rdata_o     = rdata_q;
   assign bus_cyc_o   = busy;
   assign bus_we_o    = busy && write_q;
   assign bus_addr_o  = cur_addr;
   assign bus_be_o    = busy ? be : 4'd0;
   assign bus_wdata_o = wbus;
endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid_i,
   input logic              bus_ack_i,
   input logic              busy_o,
   input logic              err_o,
   input logic              beat_o,
   input logic              done_o,
   input logic              bus_cyc_o,
   input logic              bus_we_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic [3:0]        bus_be_o,
   input logic [31:0]       bus_wdata_o
);
   assert_hold_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc_o && !bus_ack_i) |=> ($stable(bus_addr_o) && $stable(bus_be_o) && $stable(bus_wdata_o)));

   assert_start_from_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(req_valid_i));

   assert_done_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(busy_o && bus_ack_i) && !busy_o && beat_o));

   assert_single_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, err_o}));

   assert_refusal_no_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!bus_cyc_o && !beat_o));

   assert_enables_with_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc_o |-> (bus_be_o != 4'd0));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cyc_o |-> (bus_be_o == 4'd0 && !bus_we_o));
endmodule

bind endian_width_adapter ebw_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid_i (req_valid_i),
   .bus_ack_i   (bus_ack_i),
   .busy_o      (busy_o),
   .err_o       (err_o),
   .beat_o      (beat_o),
   .done_o      (done_o),
   .bus_cyc_o   (bus_cyc_o),
   .bus_we_o    (bus_we_o),
   .bus_addr_o  (bus_addr_o),
   .bus_be_o    (bus_be_o),
   .bus_wdata_o (bus_wdata_o)
);

// File: tb/sim_endian_width_adapter.sv
`timescale 1ns/1ps
module sim_endian_width_adapter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_le_i = 1'b0;
   logic [1:0]  bus_width_i = 2'd0;
   logic        narrow_region_i = 1'b0;
   logic        req_valid_i = 1'b0;
   logic        req_write_i = 1'b0;
   logic [2:0]  req_size_i = 3'd0;
   logic [31:0] req_addr_i = '0;
   logic [31:0] req_wdata_i = '0;
   logic        busy_o, err_o, beat_o, done_o, bus_cyc_o, bus_we_o;
   logic [31:0] rdata_o, bus_addr_o, bus_wdata_o;
   logic [3:0]  bus_be_o;
   logic [31:0] bus_rdata_i = '0;
   logic        bus_ack_i = 1'b0;

   always #2.5 clk = ~clk;

   endian_width_adapter u0 (
      .clk(clk), .rst_n(rst_n), .mode_le_i(mode_le_i), .bus_width_i(bus_width_i),
      .narrow_region_i(narrow_region_i), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
      .req_size_i(req_size_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
      .busy_o(busy_o), .err_o(err_o), .beat_o(beat_o), .done_o(done_o), .rdata_o(rdata_o),
      .bus_cyc_o(bus_cyc_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_be_o(bus_be_o),
      .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i)
   );

   int checks = 0;
   int fails = 0;
   bit le_mode = 1'b0;
   logic [7:0]  mem [0:255];
   logic [7:0]  emem [0:255];
   logic [31:0] got [0:7];
   logic [31:0] wv [0:7];
   int  ncyc, nbeat;
   bit  saw_err, saw_done, first_busy;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int item_addr(int addr, int sz, int j);
      int blk, base;
      if (sz < 3) return addr;
      blk  = 1 << sz;
      base = addr & ~(blk - 1);
      return base + ((addr - base + 4 * j) % blk);
   endfunction

   function automatic int item_bytes(int sz);
      return (sz < 3) ? (1 << sz) : 4;
   endfunction

   function automatic int cyc_addr(int addr, int sz, int wsh, int k);
      int s, w, spl;
      s = item_bytes(sz);
      w = 1 << wsh;
      spl = (s > w) ? s / w : 1;
      return item_addr(addr, sz, k / spl) + (k % spl) * w;
   endfunction

   function automatic logic [31:0] value_at(int a, int s);
      logic [31:0] v;
      int pos;
      v = '0;
      for (int i = 0; i < s; i++) begin
         pos = le_mode ? i : (s - 1 - i);
         v[pos*8 +: 8] = mem[(a + i) & 255];
      end
      return v;
   endfunction

   task automatic run_xfer(input bit wr, input int sz, input int addr, input int wsh, input bit narrow,
                           input int waits, input int inject, input string tag);
      int s, w, spl, nlw, total, wc, n_exp, a;
      bit fin;
      logic [31:0] rd;
      s = item_bytes(sz);
      w = 1 << wsh;
      spl = (s > w) ? s / w : 1;
      nlw = (sz >= 3) ? (1 << sz) / 4 : 1;
      total = spl * nlw;
      n_exp = (s < w) ? s : w;
      ncyc = 0; nbeat = 0; saw_err = 0; saw_done = 0; wc = 0; fin = 0;
      @(negedge clk);
      req_valid_i = 1'b1; req_write_i = wr; req_size_i = 3'(sz); req_addr_i = 32'(addr);
      bus_width_i = 2'(wsh); narrow_region_i = narrow; req_wdata_i = wv[0];
      for (int it = 0; it < 600 && !fin; it++) begin
         @(negedge clk);
         if (it == 0) first_busy = busy_o;
         if (it == inject) begin
            req_valid_i = 1'b1; req_write_i = 1'b0; req_size_i = 3'd0; req_addr_i = 32'h30;
         end else begin
            req_valid_i = 1'b0;
         end
         if (beat_o) begin
            if (nbeat < 8) got[nbeat] = rdata_o;
            nbeat++;
         end
         if (err_o) begin saw_err = 1; fin = 1; end
         if (done_o) begin saw_done = 1; fin = 1; end
         bus_ack_i = 1'b0;
         if (bus_cyc_o && !fin) begin
            if (wc < waits) wc++;
            else begin
               wc = 0;
               chk(bus_addr_o == 32'(cyc_addr(addr, sz, wsh, ncyc)), {tag, " address order"},
                   bus_addr_o, 32'(cyc_addr(addr, sz, wsh, ncyc)));
               chk(($countones(bus_be_o) == n_exp) && ((bus_be_o >> w) == 4'd0), "R3 lane enables",
                   32'(bus_be_o), 32'(n_exp));
               chk(bus_we_o == wr, "R3 write flag", 32'(bus_we_o), 32'(wr));
               rd = 32'hEEEE_EEEE;
               for (int l = 0; l < w; l++) begin
                  a = ((int'(bus_addr_o) & ~(w - 1)) + (le_mode ? l : (w - 1 - l))) & 255;
                  if (wr && bus_be_o[l]) mem[a] = bus_wdata_o[l*8 +: 8];
                  if (!wr) rd[l*8 +: 8] = mem[a];
               end
               bus_rdata_i = rd;
               bus_ack_i = 1'b1;
               if (wr && ((ncyc + 1) % spl == 0) && ((ncyc + 1) / spl < nlw))
                  req_wdata_i = wv[(ncyc + 1) / spl];
               ncyc++;
            end
         end
      end
      bus_ack_i = 1'b0;
      req_valid_i = 1'b0;
      if (!fin) chk(1'b0, {tag, " transfer timed out"}, 32'(ncyc), 32'(total));
      if (!saw_err) begin
         chk(ncyc == total, {tag, " cycle count"}, 32'(ncyc), 32'(total));
         chk(nbeat == nlw, "R5 beat count", 32'(nbeat), 32'(nlw));
         chk(saw_done, "R5 done pulse", 32'(saw_done), 32'd1);
         chk(first_busy, "R8 busy after accept", 32'(first_busy), 32'd1);
      end
   endtask

   task automatic do_read(input int sz, input int addr, input int wsh, input int waits, input string tag);
      int s;
      s = item_bytes(sz);
      run_xfer(1'b0, sz, addr, wsh, 1'b0, waits, -1, tag);
      for (int j = 0; j < ((sz >= 3) ? (1 << sz) / 4 : 1); j++)
         chk(got[j] == value_at(item_addr(addr, sz, j), s), "R4 read value",
             got[j], value_at(item_addr(addr, sz, j), s));
   endtask

   task automatic do_write(input int sz, input int addr, input int wsh, input int waits, input string tag);
      int s, nlw, a, pos, bad;
      s = item_bytes(sz);
      nlw = (sz >= 3) ? (1 << sz) / 4 : 1;
      for (int i = 0; i < 256; i++) emem[i] = mem[i];
      for (int j = 0; j < nlw; j++) begin
         wv[j] = 32'h8C4D_1E27 ^ (32'(j) * 32'h1111_0F0F) ^ 32'(addr);
         a = item_addr(addr, sz, j);
         for (int i = 0; i < s; i++) begin
            pos = le_mode ? i : (s - 1 - i);
            emem[(a + i) & 255] = wv[j][pos*8 +: 8];
         end
      end
      run_xfer(1'b1, sz, addr, wsh, 1'b0, waits, -1, tag);
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) bad++;
      chk(bad == 0, (sz >= 3) ? "R7 burst write memory image" : "R4 write memory image", 32'(bad), 32'd0);
   endtask

   task automatic do_bad(input int sz, input int addr, input int wsh, input bit narrow, input string tag);
      run_xfer(1'b0, sz, addr, wsh, narrow, 0, -1, tag);
      chk(saw_err && ncyc == 0 && !saw_done, {tag, " refusal"}, 32'(ncyc), 32'd0);
      @(negedge clk);
      chk(!err_o && !bus_cyc_o && !busy_o, {tag, " no bus cycle after refusal"}, 32'(bus_cyc_o), 32'd0);
   endtask

   task automatic do_reset(input bit m);
      @(negedge clk);
      rst_n = 1'b0; mode_le_i = m; le_mode = m;
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 29 + 11) ^ (i >> 3));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !bus_cyc_o && bus_be_o == 4'd0 && !err_o && !done_o && !beat_o,
          "R8 reset state", {busy_o, bus_cyc_o, bus_be_o, err_o, done_o, beat_o}, 32'd0);
   endtask

   task automatic t_singles;
      do_read(0, 32'h03, 2, 0, "R2");
      do_read(1, 32'h06, 1, 0, "R2");
      do_read(2, 32'h08, 0, 0, "R2");
      do_read(2, 32'h0C, 2, 0, "R2");
      do_read(1, 32'h0A, 0, 2, "R9");
      do_read(0, 32'h0D, 1, 1, "R3");
      do_write(1, 32'h12, 0, 0, "R2");
      do_write(2, 32'h14, 1, 1, "R2");
      do_write(0, 32'h19, 2, 0, "R3");
      do_write(1, 32'h1E, 2, 0, "R3");
   endtask

   task automatic t_bursts;
      do_read(5, 32'h54, 1, 1, "R6");
      do_write(3, 32'h6C, 0, 0, "R6");
      do_read(4, 32'h88, 2, 0, "R6");
      do_write(5, 32'hA4, 2, 1, "R6");
   endtask

   task automatic t_refusals;
      do_bad(1, 32'h11, 2, 1'b0, "R10");
      do_bad(2, 32'h22, 0, 1'b0, "R10");
      do_bad(4, 32'h42, 1, 1'b0, "R10");
      do_bad(0, 32'h40, 3, 1'b0, "R11");
      do_bad(2, 32'h40, 2, 1'b1, "R11");
      do_bad(6, 32'h40, 0, 1'b0, "R11");
   endtask

   task automatic t_busy_ignore;
      run_xfer(1'b0, 2, 32'h20, 0, 1'b0, 1, 3, "R8");
      chk(got[0] == value_at(32'h20, 4), "R8 value undisturbed", got[0], value_at(32'h20, 4));
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(!bus_cyc_o && !busy_o, "R8 ignored request left no cycle", 32'(bus_cyc_o), 32'd0);
      end
   endtask

   task automatic t_mode_hold;
      mode_le_i = ~le_mode;
      do_read(1, 32'h32, 1, 0, "R1");
      do_read(2, 32'h34, 0, 0, "R1");
   endtask

   initial begin
      do_reset(1'b0);
      t_singles;
      t_bursts;
      t_refusals;
      t_busy_ignore;
      t_mode_hold;
      do_reset(1'b1);
      t_singles;
      t_bursts;
      t_refusals;
      t_mode_hold;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule